// File: doc/BRIEF.md
# Multiplexed LCD Row-Scan Controller

This block produces the row-by-row scan of a dot-matrix LCD. Each time the scan clock enable pulses, it reads one display row out of a four-bank display memory. The memory holds eight pixel rows per bank, packed as one byte per column. The block walks the 32 displayable columns (memory columns 8 to 39; columns 0 to 7 hold data that is never shown), picks the one bit of each byte that belongs to the current row, and packs the result into a 32-bit column word. It then presents that word together with the row index and a frame-start flag. The row period is set by the spacing of the scan enable pulses, and the block is idle between rows.

Three mode inputs shape a frame. The multiplex select sets how many rows form a frame. The display-status select can blank the panel, light every dot, or pass the memory data through, either as it is or inverted. The start-bank select chooses which memory bank forms the top of the display, so that text can be scrolled by switching banks. The active copy of all three is loaded only when row 0 of a frame begins, so a frame is never drawn with mixed settings.

The sequencer has four named states. WAIT idles until scan_en is seen (transition WAIT->FETCH, the row start). FETCH issues one read per cycle for columns 8 to 39 and leaves after column 39 (FETCH->LAST). LAST absorbs the final read byte (LAST->EMIT). EMIT publishes the finished row and advances the row counter (EMIT->WAIT).

Top module: `lcdscan_ctrl`

## Requirements
- R1: The number of rows per frame is 8 x (mux_sel + 1): mux_sel 00, 01, 10 and 11 give 8, 16, 24 and 32 rows. row_idx counts 0, 1, ... up to that count minus one and then returns to 0.
- R2: disp_sel is decoded as follows: 00 blank (col_data all zeros), 01 normal (memory bits unchanged), 10 all on (col_data all ones) and 11 inverse (memory bits complemented). Blank and all on ignore the memory contents.
- R3: For display row r, the bank read is (active start bank + r/8) mod 4, and the bit taken from each byte is bit (r mod 8). Bit i of col_data holds memory column 8 + i.
- R4: Each row issues exactly 32 reads, one per cycle, at columns 8, 9, ..., 39 in ascending order. No read is issued to columns 0 to 7. ram_addr[7:6] carries the bank and ram_addr[5:0] carries the column. Read data is expected on ram_rdata one cycle after the read.
- R5: mux_sel, disp_sel and start_bank are loaded only in the cycle in which scan_en starts row 0. A value presented in that same cycle takes effect. A change during any other row is not used until the next frame.
- R6: frame_start is high exactly while the published row is row 0, and low for every other row.
- R7: row_valid pulses high for one cycle on the 35th rising edge, counting the edge that samples scan_en high as the first. col_data, row_idx and frame_start change only at that edge and hold their values until the next row is published.
- R8: A scan_en pulse that arrives while a row is still being fetched or published is ignored. It produces no extra row and does not disturb the current one.
- R9: After reset, col_data, row_idx, frame_start, row_valid and ram_rd_en are all zero, and the first row scanned is row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Scan clock enable; one pulse starts one row |
| mux_sel | input | 2 | Multiplex select (rows per frame) |
| disp_sel | input | 2 | Display status select |
| start_bank | input | 2 | Bank shown at the top of the display |
| ram_rd_en | output | 1 | Display memory read strobe |
| ram_addr | output | 8 | Read address: bank in [7:6], column in [5:0] |
| ram_rdata | input | 8 | Read byte, valid one cycle after ram_rd_en |
| col_data | output | 32 | Column word of the published row |
| row_idx | output | 5 | Index of the published row |
| frame_start | output | 1 | High while the published row is row 0 |
| row_valid | output | 1 | One-cycle pulse when a new row is published |

## Verification
Loading the mode settings and starting a row can fall in the same cycle. In that case, new settings must be taken exactly when the pulse starts row 0, and must be left alone when it starts any other row. The bench changes mux_sel, disp_sel and start_bank on the very cycle of a row-0 pulse, and also in the middle of a frame. Its scoreboard model applies the settings only at its own row-0 event, so a controller that loads them one row too early or too late publishes row words, bank choices or frame lengths that do not match. Starting a row and the row counter wrapping also meet when the last row of a frame is followed directly by row 0. This is judged through row_idx, frame_start and the length of each frame.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LAST  = 2'd2,
        ST_EMIT  = 2'd3
    } scan_state_e;

    typedef enum logic [1:0] {
        DISP_BLANK   = 2'b00,
        DISP_NORMAL  = 2'b01,
        DISP_ALL_ON  = 2'b10,
        DISP_INVERSE = 2'b11
    } disp_mode_e;

endpackage

// File: rtl/lcdscan_row_seq.sv
module lcdscan_row_seq
    import lcdscan_pkg::*;
#(
    parameter int ROWS_PER_BANK = 8,
    parameter int NUM_BANKS     = 4,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int BIT_W  = $clog2(ROWS_PER_BANK),
    localparam int ROW_W  = BANK_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start,
    input  logic              row_done,
    input  logic [BANK_W-1:0] mux_in,
    input  logic [1:0]        status_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [ROW_W-1:0]  row_cnt,
    output disp_mode_e        act_status,
    output logic [BANK_W-1:0] bank_sel,
    output logic [BIT_W-1:0]  bit_sel
);

    logic [BANK_W-1:0] act_mux_q;
    logic [BANK_W-1:0] act_bank_q;
    disp_mode_e        act_status_q;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W-1:0]  rows_m1;
    logic              frame_load;

    // Settings are only taken in when a frame begins
    assign frame_load = row_start && (row_q == '0);
    assign rows_m1    = ROW_W'((32'(act_mux_q) + 32'd1) * ROWS_PER_BANK - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mux_q    <= '0;
            act_bank_q   <= '0;
            act_status_q <= DISP_BLANK;
        end else if (frame_load) begin
            act_mux_q    <= mux_in;
            act_bank_q   <= bank_in;
            act_status_q <= disp_mode_e'(status_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (row_done) begin
            if (row_q == rows_m1) begin
                row_q <= '0;
            end else begin
                row_q <= row_q + ROW_W'(1);
            end
        end
    end

    // Bank for row r: start bank plus r / rows-per-bank, wrapping with the bank width
    assign bank_sel   = act_bank_q + row_q[ROW_W-1:BIT_W];
    assign bit_sel    = row_q[BIT_W-1:0];
    assign row_cnt    = row_q;
    assign act_status = act_status_q;

    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= rows_m1); // R1
    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (row_done && row_q == rows_m1) |=> (row_q == '0)); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> ($stable(act_bank_q) && $stable(act_mux_q) && $stable(act_status_q))); // R5

endmodule

// File: rtl/lcdscan_col_fetch.sv
module lcdscan_col_fetch
    import lcdscan_pkg::*;
#(
    parameter int COL_FIRST     = 8,
    parameter int COL_LAST      = 39,
    parameter int ROWS_PER_BANK = 8,
    parameter int NUM_BANKS     = 4,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int BIT_W  = $clog2(ROWS_PER_BANK),
    localparam int COL_W  = $clog2(COL_LAST + 1),
    localparam int ADDR_W = BANK_W + COL_W,
    localparam int DATA_W = COL_LAST - COL_FIRST + 1,
    localparam int OFF_W  = $clog2(DATA_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scan_en,
    input  logic [BANK_W-1:0]        bank_sel,
    input  logic [BIT_W-1:0]         bit_sel,
    output logic                     ram_rd_en,
    output logic [ADDR_W-1:0]        ram_addr,
    input  logic [ROWS_PER_BANK-1:0] ram_rdata,
    output logic                     row_start,
    output logic                     row_done,
    output logic [DATA_W-1:0]        asm_data
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(DATA_W - 1);

    scan_state_e       state_q, state_d;
    logic [OFF_W-1:0]  off_q;
    logic              pend_q;
    logic [DATA_W-1:0] asm_q;
    logic [COL_W-1:0]  col;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (scan_en) state_d = ST_FETCH;
            ST_FETCH: if (off_q == LAST_OFF) state_d = ST_LAST;
            ST_LAST:  state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_WAIT;
        endcase
    end

    assign col = COL_W'(COL_FIRST) + COL_W'(off_q);

    // Outputs decoded from the state
    always_comb begin
        ram_rd_en = 1'b0;
        row_start = 1'b0;
        row_done  = 1'b0;
        unique case (state_q)
            ST_WAIT:  row_start = scan_en;
            ST_FETCH: ram_rd_en = 1'b1;
            ST_LAST:  ;
            ST_EMIT:  row_done  = 1'b1;
        endcase
    end

    assign ram_addr = {bank_sel, col};

    // Column offset inside the displayable window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (row_start) begin
            off_q <= '0;
        end else if (state_q == ST_FETCH && off_q != LAST_OFF) begin
            off_q <= off_q + OFF_W'(1);
        end
    end

    // One-cycle read latency: capture the row's bit a cycle after each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            asm_q  <= '0;
        end else begin
            pend_q <= ram_rd_en;
            if (pend_q) begin
                asm_q <= {ram_rdata[bit_sel], asm_q[DATA_W-1:1]};
            end
        end
    end

    assign asm_data = asm_q;

    AST_COL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> (col >= COL_W'(COL_FIRST) && col <= COL_W'(COL_LAST))); // R4
    AST_COL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en && $past(ram_rd_en)) |-> (col == $past(col) + COL_W'(1))); // R4
    AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> (ram_rd_en && col == COL_W'(COL_FIRST))); // R4
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && off_q != LAST_OFF) |=> (state_q == ST_FETCH && off_q == $past(off_q) + OFF_W'(1))); // R8

endmodule

// File: rtl/lcdscan_out_stage.sv
module lcdscan_out_stage
    import lcdscan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_done,
    input  logic [DATA_W-1:0] asm_data,
    input  disp_mode_e        act_status,
    input  logic [ROW_W-1:0]  row_cnt,
    output logic [DATA_W-1:0] col_data,
    output logic [ROW_W-1:0]  row_idx,
    output logic              frame_start,
    output logic              row_valid
);

    logic [DATA_W-1:0] shaped;

    always_comb begin
        unique case (act_status)
            DISP_BLANK:   shaped = '0;
            DISP_NORMAL:  shaped = asm_data;
            DISP_ALL_ON:  shaped = '1;
            DISP_INVERSE: shaped = ~asm_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_data    <= '0;
            row_idx     <= '0;
            frame_start <= 1'b0;
            row_valid   <= 1'b0;
        end else begin
            row_valid <= row_done;
            if (row_done) begin
                col_data    <= shaped;
                row_idx     <= row_cnt;
                frame_start <= (row_cnt == '0);
            end
        end
    end

    AST_FRAME_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_idx == '0)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |=> !row_valid); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !row_done |=> ($stable(col_data) && $stable(row_idx) && $stable(frame_start))); // R7
    AST_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && act_status == DISP_BLANK) |-> (col_data == '0)); // R2
    AST_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && act_status == DISP_ALL_ON) |-> (col_data == '1)); // R2

endmodule

// File: rtl/lcdscan_ctrl.sv
module lcdscan_ctrl
    import lcdscan_pkg::*;
#(
    parameter int COL_FIRST     = 8,
    parameter int COL_LAST      = 39,
    parameter int ROWS_PER_BANK = 8,
    parameter int NUM_BANKS     = 4,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int BIT_W  = $clog2(ROWS_PER_BANK),
    localparam int ROW_W  = BANK_W + BIT_W,
    localparam int COL_W  = $clog2(COL_LAST + 1),
    localparam int ADDR_W = BANK_W + COL_W,
    localparam int DATA_W = COL_LAST - COL_FIRST + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scan_en,
    input  logic [BANK_W-1:0]        mux_sel,
    input  logic [1:0]               disp_sel,
    input  logic [BANK_W-1:0]        start_bank,
    output logic                     ram_rd_en,
    output logic [ADDR_W-1:0]        ram_addr,
    input  logic [ROWS_PER_BANK-1:0] ram_rdata,
    output logic [DATA_W-1:0]        col_data,
    output logic [ROW_W-1:0]         row_idx,
    output logic                     frame_start,
    output logic                     row_valid
);

    logic              row_start;
    logic              row_done;
    logic [ROW_W-1:0]  row_cnt;
    disp_mode_e        act_status;
    logic [BANK_W-1:0] bank_sel;
    logic [BIT_W-1:0]  bit_sel;
    logic [DATA_W-1:0] asm_data;

    lcdscan_row_seq #(
        .ROWS_PER_BANK (ROWS_PER_BANK),
        .NUM_BANKS     (NUM_BANKS)
    ) u_row_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_start  (row_start),
        .row_done   (row_done),
        .mux_in     (mux_sel),
        .status_in  (disp_sel),
        .bank_in    (start_bank),
        .row_cnt    (row_cnt),
        .act_status (act_status),
        .bank_sel   (bank_sel),
        .bit_sel    (bit_sel)
    );

    lcdscan_col_fetch #(
        .COL_FIRST     (COL_FIRST),
        .COL_LAST      (COL_LAST),
        .ROWS_PER_BANK (ROWS_PER_BANK),
        .NUM_BANKS     (NUM_BANKS)
    ) u_col_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .bank_sel  (bank_sel),
        .bit_sel   (bit_sel),
        .ram_rd_en (ram_rd_en),
        .ram_addr  (ram_addr),
        .ram_rdata (ram_rdata),
        .row_start (row_start),
        .row_done  (row_done),
        .asm_data  (asm_data)
    );

    lcdscan_out_stage #(
        .DATA_W (DATA_W),
        .ROW_W  (ROW_W)
    ) u_out_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_done    (row_done),
        .asm_data    (asm_data),
        .act_status  (act_status),
        .row_cnt     (row_cnt),
        .col_data    (col_data),
        .row_idx     (row_idx),
        .frame_start (frame_start),
        .row_valid   (row_valid)
    );

endmodule

// File: tb/lcdscan_ctrl_tb.sv
`timescale 1ns/1ps
module lcdscan_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_en;
    logic [1:0]  mux_sel, disp_sel, start_bank;
    logic        ram_rd_en;
    logic [7:0]  ram_addr;
    logic [7:0]  ram_rdata;
    logic [31:0] col_data;
    logic [4:0]  row_idx;
    logic        frame_start, row_valid;

    always #2 clk = ~clk;

    lcdscan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
        .mux_sel(mux_sel), .disp_sel(disp_sel), .start_bank(start_bank),
        .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .col_data(col_data), .row_idx(row_idx),
        .frame_start(frame_start), .row_valid(row_valid)
    );

    // Display memory model: synchronous read, one cycle latency
    logic [7:0] mem [4][64];
    always @(posedge clk) begin
        if (ram_rd_en) ram_rdata <= mem[ram_addr[7:6]][ram_addr[5:0]];
    end

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int          row;
        logic [31:0] data;
        bit          fs;
        int          pcyc;
    } exp_t;
    exp_t sbq[$];

    int         exp_row = 0;
    logic [1:0] a_mux = 2'd0, a_stat = 2'd0, a_bank = 2'd0;

    function automatic logic [31:0] exp_word(int r, logic [1:0] st, logic [1:0] bk);
        logic [31:0] w;
        logic [1:0]  b;
        b = 2'(bk + 2'(r / 8));
        for (int i = 0; i < 32; i++) w[i] = mem[b][8 + i][r % 8];
        case (st)
            2'b00:   return 32'h0;
            2'b01:   return w;
            2'b10:   return 32'hFFFF_FFFF;
            default: return ~w;
        endcase
    endfunction

    // Driver: one row period of 40 cycles, optional settings change on the pulse
    // cycle, optional extra pulse while the row is busy (must be ignored, R8)
    task automatic scan_row(input bit chg, input logic [1:0] m, input logic [1:0] s,
                            input logic [1:0] b, input bit busy);
        exp_t it;
        @(negedge clk);
        if (chg) begin
            mux_sel = m; disp_sel = s; start_bank = b;
        end
        scan_en = 1'b1;
        if (exp_row == 0) begin
            a_mux = mux_sel; a_stat = disp_sel; a_bank = start_bank;
        end
        it.row  = exp_row;
        it.data = exp_word(exp_row, a_stat, a_bank);
        it.fs   = (exp_row == 0);
        it.pcyc = cyc;
        sbq.push_back(it);
        exp_row = (exp_row == (int'(a_mux) + 1) * 8 - 1) ? 0 : exp_row + 1;
        @(negedge clk);
        scan_en = 1'b0;
        if (busy) begin
            repeat (4) @(negedge clk);
            scan_en = 1'b1;
            @(negedge clk);
            scan_en = 1'b0;
            repeat (33) @(negedge clk);
        end else begin
            repeat (38) @(negedge clk);
        end
    endtask

    task automatic run_rows(input int n);
        for (int k = 0; k < n; k++) scan_row(1'b0, 2'd0, 2'd0, 2'd0, 1'b0);
    endtask

    // Monitor: scoreboard compare, read-address sequence, output hold
    bit          prev_rd = 1'b0;
    int          exp_col = 8;
    int          since_valid = 0;
    bit          have_row = 1'b0;
    logic [31:0] last_data;
    logic [4:0]  last_row;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ram_rd_en) begin
                if (!prev_rd) exp_col = 8;
                chk(ram_addr[5:0] == 6'(exp_col), "R4", "read column",
                    64'(ram_addr[5:0]), 64'(exp_col));
                exp_col++;
            end
            prev_rd = ram_rd_en;

            if (row_valid) begin
                exp_t it;
                chk(exp_col == 40, "R4", "reads per row end column", 64'(exp_col), 64'd40);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R8", "unexpected row published", 64'(row_idx), 64'd0);
                end else begin
                    it = sbq.pop_front();
                    chk(row_idx == 5'(it.row), "R1", "row_idx", 64'(row_idx), 64'(it.row));
                    chk(col_data == it.data, "R2 R3", "col_data", 64'(col_data), 64'(it.data));
                    chk(frame_start == it.fs, "R6", "frame_start", 64'(frame_start), 64'(it.fs));
                    chk(cyc - it.pcyc == 35, "R7", "latency", 64'(cyc - it.pcyc), 64'd35);
                end
                last_data = col_data;
                last_row = row_idx;
                have_row = 1'b1;
                since_valid = 0;
            end else if (have_row) begin
                since_valid++;
                if (since_valid == 10) begin
                    chk(col_data == last_data && row_idx == last_row && !row_valid, "R7",
                        "outputs held", 64'(col_data), 64'(last_data));
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < 64; c++)
                mem[b][c] = 8'((b * 73 + c * 29 + 17) ^ (c * 5) ^ (b << 5));
        rst_n = 1'b0; scan_en = 1'b0;
        mux_sel = 2'd0; disp_sel = 2'b01; start_bank = 2'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(col_data == 32'h0, "R9", "col_data after reset", 64'(col_data), 64'd0);
        chk(row_idx == 5'd0 && !frame_start, "R9", "row/frame after reset",
            64'({row_idx, frame_start}), 64'd0);
        chk(!row_valid && !ram_rd_en, "R9", "valid/read after reset",
            64'({row_valid, ram_rd_en}), 64'd0);

        // Frame of 8 rows, normal video, bank 0; settings changed mid-frame (R5)
        scan_row(1'b0, 2'd0, 2'd0, 2'd0, 1'b0);
        mux_sel = 2'd1; disp_sel = 2'b11; start_bank = 2'd2;
        run_rows(7);
        // Next frame picks up 16 rows, inverse, bank 2 (R1, R2, R3, R5)
        run_rows(16);
        // New settings presented on the very cycle of the row-0 pulse (R5)
        scan_row(1'b1, 2'd3, 2'b10, 2'd3, 1'b0);
        // Change on a non-zero row pulse must not apply (R5), with busy pulses (R8)
        scan_row(1'b1, 2'd2, 2'b00, 2'd1, 1'b1);
        run_rows(29);
        scan_row(1'b0, 2'd0, 2'd0, 2'd0, 1'b1);
        // Frame of 24 rows, blank (R1, R2)
        run_rows(23);
        // 32 rows, normal video, start bank 3: bank wraps modulo 4 (R3)
        scan_row(1'b1, 2'd3, 2'b01, 2'd3, 1'b0);
        run_rows(31);
        // 8 rows, inverse, start bank 1
        scan_row(1'b1, 2'd0, 2'b11, 2'd1, 1'b0);
        run_rows(7);
        scan_row(1'b0, 2'd0, 2'd0, 2'd0, 1'b0);

        repeat (50) @(negedge clk);
        chk(sbq.size() == 0, "R7", "all expected rows published", 64'(sbq.size()), 64'd0);
        finish_run();
    end

endmodule